// File: doc/BRIEF.md
# MDIO Management Bridge with Coherent Status Snapshot

This block is a clause 22 management-bus master for PHY devices, controlled by a host through a byte-wide register window (for example a serial slave port that turns host transfers into byte reads and writes). The host places one 32-bit command word into four consecutive bytes. Writing the top byte launches a read or write frame on the management clock and data lines. The host then polls the same word to learn whether the frame is still running and, for reads, what value came back.

A host that reads the word one byte at a time could see a torn result: the low bytes before a frame ends and the busy flag after it. To prevent this, a read of the base byte takes a snapshot of the busy flag and the returned data together. The remaining bytes are served from that snapshot. If a frame finishes partway through a poll, the host sees busy with the old data and picks up the new value on its next poll.

The management clock runs at one of two rates, chosen per command: a normal rate and a rate ten times slower. The data line is split into output, output-enable and input signals, so that the pad can be built outside this block.

Top module: `mdio_reg_bridge`

## Requirements
- R1: After reset, mdc and mdio_oe are low, host_rdata is 0x00, and a poll of the command word returns busy = 0 and read data 0x0000.
- R2: The command word occupies byte addresses 0x004C to 0x004F, little endian. Its write layout is: bits [15:0] write data, [20:16] register address, [25:21] PHY address, [26] operation (1 = read, 0 = write), [27] slow rate. A write to byte 0x004F commits the word and sets the busy flag (bit 31) on that same clock edge.
- R3: A frame is 64 bit periods, sent MSB first. It consists of 32 ones, start bits 01, opcode 10 for a read or 01 for a write, the 5-bit PHY address, the 5-bit register address, turnaround 10 (write only), and 16 data bits (write only). mdio_out changes only while mdc is low, so it is stable at each rising edge of mdc.
- R4: mdio_oe is high for bit periods 0 to 45 of every frame and for periods 46 to 63 of a write frame. It is low during the turnaround and data periods of a read frame, and low whenever no frame is running.
- R5: In a read frame, mdio_in is sampled on the rising mdc edges of bit periods 48 to 63, MSB first. The read data field, bits [15:0] of the polled word, keeps its previous value during any frame and through write frames. It takes the new value only when a read frame ends.
- R6: The busy flag stays set from the commit until the clock edge on which mdc falls for the 64th time, and mdc stays low after that edge.
- R7: The mdc period is 2*DIV_FAST clocks (50 clocks by default, which is 2.5 MHz at 125 MHz) when bit 27 is 0, and 2*DIV_SLOW clocks (500 clocks, 250 kHz) when bit 27 is 1. mdc is idle low, and its first rising edge comes DIV clocks after the commit.
- R8: A read of byte 0x004C returns the live read data bits [7:0] and captures busy and read data bits [15:8]. Reads of 0x004D return the captured bits [15:8], reads of 0x004E return 0x00, and reads of 0x004F return {captured busy, 7'b0}. These values do not change even if a frame ends in between.
- R9: While busy is set, writes to 0x004C to 0x004F have no effect. They do not start a frame and they do not alter the staged command bytes.
- R10: host_rdata is updated on the clock edge that samples host_rd_en and holds its value until the next read. Addresses outside 0x004C to 0x004F read as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_wr_en | input | 1 | Host byte write strobe |
| host_rd_en | input | 1 | Host byte read strobe |
| host_addr | input | 16 | Host byte address |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, registered |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Management data, output value |
| mdio_oe | output | 1 | Management data, output enable |
| mdio_in | input | 1 | Management data, input value |

## Verification
Each result appears at a known delay after the stimulus that causes it:
- host_rdata is due one clock after a read strobe.
- Busy is due on the commit edge.
- The first rising edge of mdc is due DIV clocks after the commit.
- Busy clears and read data is updated on the edge of the 64th falling edge of mdc.

The bench drives its strobes on the falling clock edge and reads host_rdata at the next falling edge. For checks tied to the frame, it does not assume a cycle count. It counts mdc edges at the port with its own PHY model and places its polls relative to those edges. This includes the torn-poll case, where the base byte is read after the 64th rising edge and the upper bytes after the 64th falling edge. Period checks measure the clock cycles between the first two rising edges of mdc.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int FRAME_BITS = 64;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam int TA_FIRST   = 46;  // first bit period released in a read
  localparam int DATA_FIRST = 48;  // first sampled bit period in a read

  // packed so that bit positions match the host command word layout
  typedef struct packed {
    logic        slow;     // [27]
    logic        is_read;  // [26]
    logic [4:0]  phy;      // [25:21]
    logic [4:0]  regad;    // [20:16]
    logic [15:0] wdata;    // [15:0]
  } mdio_cmd_t;

  localparam int CMD_W = $bits(mdio_cmd_t);

  function automatic logic [FRAME_BITS-1:0] build_frame(mdio_cmd_t c);
    logic [1:0]  op;
    logic [1:0]  ta;
    logic [15:0] dat;
    op  = c.is_read ? 2'b10 : 2'b01;
    ta  = c.is_read ? 2'b00 : 2'b10;
    dat = c.is_read ? 16'h0000 : c.wdata;
    return {32'hFFFF_FFFF, 2'b01, op, c.phy, c.regad, ta, dat};
  endfunction

endpackage

// File: rtl/mdc_timer.sv
module mdc_timer #(
  parameter int DIV_FAST = 25,
  parameter int DIV_SLOW = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic slow,
  output logic tick
);
  localparam int CW = $clog2(DIV_SLOW + 1);
  localparam logic [CW-1:0] LIM_FAST = CW'(DIV_FAST - 1);
  localparam logic [CW-1:0] LIM_SLOW = CW'(DIV_SLOW - 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic [CW-1:0] lim;

  always_comb begin
    lim   = slow ? LIM_SLOW : LIM_FAST;
    tick  = run && (cnt_q == lim);
    cnt_n = cnt_q;
    if (!run)      cnt_n = '0;
    else if (tick) cnt_n = '0;
    else           cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
#(
  parameter int DIV_FAST = 25,
  parameter int DIV_SLOW = 250
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  mdio_cmd_t        cmd_in,
  input  logic             mdio_in,
  output logic             busy,
  output logic             mdc,
  output logic             mdio_out,
  output logic             mdio_oe,
  output logic [15:0]      rd_data,
  output logic [IDX_W-1:0] bit_idx,
  output mdio_cmd_t        cmd_act
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(TA_FIRST);
  localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(DATA_FIRST);

  logic                  busy_q, busy_n;
  logic                  mdc_q, mdc_n;
  logic [IDX_W-1:0]      idx_q, idx_n;
  logic [FRAME_BITS-1:0] sr_q, sr_n;
  logic [15:0]           rx_q, rx_n;
  logic [15:0]           rd_q, rd_n;
  mdio_cmd_t             cmd_q, cmd_n;
  logic                  tick, rise, fall;

  mdc_timer #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy_q),
    .slow (cmd_q.slow),
    .tick (tick)
  );

  assign rise = busy_q && tick && !mdc_q;
  assign fall = busy_q && tick &&  mdc_q;

  always_comb begin
    busy_n = busy_q;
    mdc_n  = mdc_q;
    idx_n  = idx_q;
    sr_n   = sr_q;
    rx_n   = rx_q;
    rd_n   = rd_q;
    cmd_n  = cmd_q;
    if (start && !busy_q) begin
      busy_n = 1'b1;
      mdc_n  = 1'b0;
      idx_n  = '0;
      sr_n   = build_frame(cmd_in);
      cmd_n  = cmd_in;
    end else if (rise) begin
      mdc_n = 1'b1;
      if (cmd_q.is_read && (idx_q >= DAT_IDX)) rx_n = {rx_q[14:0], mdio_in};
    end else if (fall) begin
      mdc_n = 1'b0;
      sr_n  = {sr_q[FRAME_BITS-2:0], 1'b0};
      idx_n = idx_q + 1'b1;
      if (idx_q == LAST_IDX) begin
        busy_n = 1'b0;
        if (cmd_q.is_read) rd_n = rx_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      mdc_q  <= 1'b0;
      idx_q  <= '0;
      sr_q   <= '0;
      rx_q   <= '0;
      rd_q   <= '0;
      cmd_q  <= '0;
    end else begin
      busy_q <= busy_n;
      mdc_q  <= mdc_n;
      idx_q  <= idx_n;
      sr_q   <= sr_n;
      rx_q   <= rx_n;
      rd_q   <= rd_n;
      cmd_q  <= cmd_n;
    end
  end

  assign busy     = busy_q;
  assign mdc      = mdc_q;
  assign mdio_out = busy_q && sr_q[FRAME_BITS-1];
  assign mdio_oe  = busy_q && ((idx_q < TA_IDX) || !cmd_q.is_read);
  assign rd_data  = rd_q;
  assign bit_idx  = idx_q;
  assign cmd_act  = cmd_q;
endmodule

// File: rtl/mdio_host_window.sv
module mdio_host_window
  import mdio_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h004C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              busy,
  input  logic [15:0]       rd_data,
  output logic              start,
  output mdio_cmd_t         cmd_out,
  output logic [7:0]        rdata,
  output logic              snap_busy,
  output logic [7:0]        snap_hi
);
  localparam int LANES    = 4;
  localparam int TOP_BITS = CMD_W - 8 * (LANES - 1);

  logic [LANES-1:0] wr_hit, rd_hit;
  logic [CMD_W-1:0] stage_q, stage_n;
  logic [7:0]       rdata_q, rdata_n;
  logic             sbusy_q, sbusy_n;
  logic [7:0]       shi_q, shi_n;

  for (genvar k = 0; k < LANES; k++) begin : g_dec
    localparam logic [ADDR_W-1:0] LANE_ADDR = BASE_ADDR + ADDR_W'(k);
    assign wr_hit[k] = wr_en && (addr == LANE_ADDR);
    assign rd_hit[k] = rd_en && (addr == LANE_ADDR);
  end

  // staging of the three full lanes
  for (genvar k = 0; k < LANES - 1; k++) begin : g_lane
    always_comb begin
      stage_n[8*k +: 8] = stage_q[8*k +: 8];
      if (wr_hit[k] && !busy) stage_n[8*k +: 8] = wdata;
    end
  end

  always_comb begin
    stage_n[CMD_W-1 -: TOP_BITS] = stage_q[CMD_W-1 -: TOP_BITS];
    if (wr_hit[LANES-1] && !busy) stage_n[CMD_W-1 -: TOP_BITS] = wdata[TOP_BITS-1:0];
  end

  assign start   = wr_hit[LANES-1] && !busy;
  assign cmd_out = mdio_cmd_t'({wdata[TOP_BITS-1:0], stage_q[CMD_W-TOP_BITS-1:0]});

  always_comb begin
    sbusy_n = sbusy_q;
    shi_n   = shi_q;
    rdata_n = rdata_q;
    if (rd_en) begin
      unique case (1'b1)
        rd_hit[0]: begin
          rdata_n = rd_data[7:0];
          sbusy_n = busy;
          shi_n   = rd_data[15:8];
        end
        rd_hit[1]: rdata_n = shi_q;
        rd_hit[3]: rdata_n = {sbusy_q, 7'b0};
        default:   rdata_n = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      rdata_q <= '0;
      sbusy_q <= 1'b0;
      shi_q   <= '0;
    end else begin
      stage_q <= stage_n;
      rdata_q <= rdata_n;
      sbusy_q <= sbusy_n;
      shi_q   <= shi_n;
    end
  end

  assign rdata     = rdata_q;
  assign snap_busy = sbusy_q;
  assign snap_hi   = shi_q;
endmodule

// File: rtl/mdio_reg_bridge.sv
module mdio_reg_bridge
  import mdio_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h004C,
  parameter int                DIV_FAST  = 25,
  parameter int                DIV_SLOW  = 250
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_en,
  input  logic              host_rd_en,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  output logic              mdc,
  output logic              mdio_out,
  output logic              mdio_oe,
  input  logic              mdio_in
);
  logic             rst_meta_q, rst_sync_q;
  logic             busy, start, snap_busy;
  logic [7:0]       snap_hi;
  logic [15:0]      rd_data;
  logic [IDX_W-1:0] bit_idx;
  mdio_cmd_t        cmd_new, cmd_act;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  mdio_host_window #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_win (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .wr_en    (host_wr_en),
    .rd_en    (host_rd_en),
    .addr     (host_addr),
    .wdata    (host_wdata),
    .busy     (busy),
    .rd_data  (rd_data),
    .start    (start),
    .cmd_out  (cmd_new),
    .rdata    (host_rdata),
    .snap_busy(snap_busy),
    .snap_hi  (snap_hi)
  );

  mdio_frame_engine #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_eng (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .start   (start),
    .cmd_in  (cmd_new),
    .mdio_in (mdio_in),
    .busy    (busy),
    .mdc     (mdc),
    .mdio_out(mdio_out),
    .mdio_oe (mdio_oe),
    .rd_data (rd_data),
    .bit_idx (bit_idx),
    .cmd_act (cmd_act)
  );
endmodule

// File: rtl/mdio_bridge_chk.sv
module mdio_bridge_chk
  import mdio_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h004C
) (
  input logic              clk,
  input logic              rst_sync_q,
  input logic              host_wr_en,
  input logic              host_rd_en,
  input logic [ADDR_W-1:0] host_addr,
  input logic              mdc,
  input logic              mdio_out,
  input logic              mdio_oe,
  input logic              busy,
  input logic [IDX_W-1:0]  bit_idx,
  input mdio_cmd_t         cmd_act,
  input logic [15:0]       rd_data,
  input logic              snap_busy,
  input logic [7:0]        snap_hi
);
  localparam logic [ADDR_W-1:0] TOP_ADDR = BASE_ADDR + ADDR_W'(3);

  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !busy |-> (!mdc && !mdio_oe));

  assert_busy_source_R2: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $rose(busy) |-> $past(host_wr_en && (host_addr == TOP_ADDR)));

  assert_read_release_R4: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (busy && cmd_act.is_read && (bit_idx >= IDX_W'(TA_FIRST))) |-> !mdio_oe);

  assert_out_hold_R3: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (mdc && $past(mdc)) |-> $stable(mdio_out));

  assert_rd_hold_R5: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !$stable(rd_data) |-> ($past(busy) && !busy && cmd_act.is_read));

  assert_snap_hold_R8: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !(host_rd_en && (host_addr == BASE_ADDR)) |=> ($stable(snap_busy) && $stable(snap_hi)));

  assert_cmd_hold_R9: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (busy && $past(busy)) |-> $stable(cmd_act));

  assert_end_edge_R6: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $fell(busy) |-> $fell(mdc));
endmodule

bind mdio_reg_bridge mdio_bridge_chk #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_chk (
  .clk       (clk),
  .rst_sync_q(rst_sync_q),
  .host_wr_en(host_wr_en),
  .host_rd_en(host_rd_en),
  .host_addr (host_addr),
  .mdc       (mdc),
  .mdio_out  (mdio_out),
  .mdio_oe   (mdio_oe),
  .busy      (busy),
  .bit_idx   (bit_idx),
  .cmd_act   (cmd_act),
  .rd_data   (rd_data),
  .snap_busy (snap_busy),
  .snap_hi   (snap_hi)
);

// File: tb/tb_mdio_reg_bridge.sv
module tb_mdio_reg_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr_en = 1'b0;
  logic        host_rd_en = 1'b0;
  logic [15:0] host_addr = 16'h0;
  logic [7:0]  host_wdata = 8'h0;
  logic [7:0]  host_rdata;
  logic        mdc, mdio_out, mdio_oe;
  logic        mdio_in = 1'b1;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  // PHY model state
  int          cnt = 0;
  int          nfall = 0;
  int          r0 = 0, r1 = 0;
  logic [63:0] cap_bit = '0, cap_oe = '0;
  logic [15:0] resp = 16'h0;

  mdio_reg_bridge dut (
    .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_rd_en(host_rd_en),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc++;

  always @(posedge mdc) begin
    if (cnt < 64) begin
      cap_bit[63-cnt] = mdio_out;
      cap_oe[63-cnt]  = mdio_oe;
    end
    if (cnt == 0) r0 = cyc;
    if (cnt == 1) r1 = cyc;
    cnt++;
  end

  always @(negedge mdc) begin
    nfall++;
    if (cnt >= 48 && cnt <= 63) mdio_in = resp[63-cnt];
    else                        mdio_in = 1'b1;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_frame(bit rd, logic [4:0] phy, logic [4:0] ra, logic [15:0] wd);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, ra, (rd ? 2'b00 : 2'b10), (rd ? 16'h0 : wd)};
  endfunction

  function automatic logic [63:0] exp_oe(bit rd);
    return {{46{1'b1}}, {18{~rd}}};
  endfunction

  task automatic hwr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); host_wr_en = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr_en = 1'b0;
  endtask

  task automatic hrd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); host_rd_en = 1'b1; host_addr = a;
    @(negedge clk); host_rd_en = 1'b0; d = host_rdata;
  endtask

  task automatic poll(output bit b, output logic [15:0] d);
    logic [7:0] lo, hi, top;
    hrd(16'h004C, lo); hrd(16'h004D, hi); hrd(16'h004F, top);
    d = {hi, lo}; b = top[7];
  endtask

  task automatic arm();
    cnt = 0; nfall = 0;
  endtask

  task automatic launch(bit rd, bit slow, logic [4:0] phy, logic [4:0] ra, logic [15:0] wd);
    hwr(16'h004C, wd[7:0]);
    hwr(16'h004D, wd[15:8]);
    hwr(16'h004E, {phy[2:0], ra});
    arm();
    hwr(16'h004F, {4'b0, slow, rd, phy[4:3]});
  endtask

  task automatic wait_done();
    wait (nfall == 64);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_frame(bit rd, bit slow, logic [4:0] phy, logic [4:0] ra, logic [15:0] wd);
    logic [63:0] e;
    e = exp_frame(rd, phy, ra, wd);
    chk(cap_bit[63:18] == e[63:18], "R3 header bits", cap_bit, e);
    if (!rd) chk(cap_bit[17:0] == e[17:0], "R3 write tail bits", cap_bit, e);
    chk(cap_oe == exp_oe(rd), "R4 output enable pattern", cap_oe, exp_oe(rd));
    chk((r1 - r0) == (slow ? 500 : 50), "R7 mdc period", r1 - r0, slow ? 500 : 50);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit          b;
    logic [15:0] d;
    logic [7:0]  bt;
    logic [15:0] last_rd;
    void'($urandom(32'd20240611));

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(mdc == 1'b0, "R1 mdc idle", mdc, 0);
    chk(mdio_oe == 1'b0, "R1 oe idle", mdio_oe, 0);
    chk(host_rdata == 8'h00, "R1 rdata", host_rdata, 0);
    poll(b, d);
    chk(b == 1'b0 && d == 16'h0, "R1 reset poll", {b, d}, 0);

    // R2 R3 R6 directed write
    launch(1'b0, 1'b0, 5'h03, 5'h09, 16'hA5C3);
    wait (nfall == 10);
    poll(b, d);
    chk(b == 1'b1 && d == 16'h0, "R6 busy mid write", {b, d}, 17'h10000);
    wait_done();
    check_frame(1'b0, 1'b0, 5'h03, 5'h09, 16'hA5C3);
    poll(b, d);
    chk(b == 1'b0 && d == 16'h0, "R5 write leaves read data", {b, d}, 0);

    // R5 directed read
    resp = 16'h7949;
    launch(1'b1, 1'b0, 5'h1A, 5'h02, 16'h0);
    wait (nfall == 20);
    poll(b, d);
    chk(b == 1'b1 && d == 16'h0, "R5 old data while busy", {b, d}, 17'h10000);
    wait_done();
    check_frame(1'b1, 1'b0, 5'h1A, 5'h02, 16'h0);
    poll(b, d);
    chk(b == 1'b0 && d == 16'h7949, "R5 read result", {b, d}, 16'h7949);
    last_rd = 16'h7949;

    // R8 frame ends in the middle of a poll
    resp = 16'h1E2D;
    launch(1'b1, 1'b0, 5'h00, 5'h00, 16'h0);
    wait (cnt == 64);
    hrd(16'h004C, bt);
    chk(bt == 8'h49, "R8 base byte before end", bt, 8'h49);
    wait (nfall == 64);
    repeat (4) @(negedge clk);
    hrd(16'h004D, bt);
    chk(bt == 8'h79, "R8 captured high byte", bt, 8'h79);
    hrd(16'h004E, bt);
    chk(bt == 8'h00, "R8 config byte reads zero", bt, 0);
    hrd(16'h004F, bt);
    chk(bt == 8'h80, "R8 captured busy", bt, 8'h80);
    poll(b, d);
    chk(b == 1'b0 && d == 16'h1E2D, "R8 next poll new value", {b, d}, 16'h1E2D);
    last_rd = 16'h1E2D;

    // R9 writes while busy are ignored
    launch(1'b0, 1'b0, 5'h07, 5'h11, 16'h1234);
    wait (nfall == 5);
    hwr(16'h004C, 8'hFF); hwr(16'h004D, 8'hFF); hwr(16'h004E, 8'hFF); hwr(16'h004F, 8'h0F);
    wait_done();
    check_frame(1'b0, 1'b0, 5'h07, 5'h11, 16'h1234);
    repeat (300) @(negedge clk);
    chk(nfall == 64 && cnt == 64, "R9 no frame from busy commit", nfall, 64);
    resp = 16'hBEEF;
    arm();
    hwr(16'h004F, 8'h04);
    wait_done();
    check_frame(1'b1, 1'b0, 5'h07, 5'h11, 16'h0);
    poll(b, d);
    chk(b == 1'b0 && d == 16'hBEEF, "R9 staged bytes kept", {b, d}, 16'hBEEF);
    last_rd = 16'hBEEF;

    // R7 slow rate
    launch(1'b0, 1'b1, 5'h1F, 5'h1F, 16'h8001);
    wait_done();
    check_frame(1'b0, 1'b1, 5'h1F, 5'h1F, 16'h8001);

    // random traffic at the normal rate
    for (int i = 0; i < 6; i++) begin
      bit          rd;
      logic [4:0]  phy, ra;
      logic [15:0] wd;
      rd   = 1'($urandom);
      phy  = 5'($urandom);
      ra   = 5'($urandom);
      wd   = 16'($urandom);
      resp = 16'($urandom);
      launch(rd, 1'b0, phy, ra, wd);
      wait_done();
      check_frame(rd, 1'b0, phy, ra, wd);
      if (rd) last_rd = resp;
      poll(b, d);
      chk(b == 1'b0 && d == last_rd, "R5 random poll", {b, d}, last_rd);
    end

    // R10 outside addresses and hold
    hrd(16'h0050, bt);
    chk(bt == 8'h00, "R10 address above window", bt, 0);
    hrd(16'h004D, bt);
    repeat (3) @(negedge clk);
    chk(host_rdata == last_rd[15:8], "R10 rdata holds", host_rdata, last_rd[15:8]);
    hrd(16'h004B, bt);
    chk(bt == 8'h00, "R10 address below window", bt, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule